// File: doc/BRIEF.md
# Calibration Table Linear Interpolator

This block turns a temperature sensor code into a tuning word for an oscillator's varactor DAC. A table of calibration pairs is loaded once, each pair joining one sensor code to the DAC value that centred the frequency at that temperature. The pairs may sit at any sensor codes, so the spacing is uneven, but the codes must rise strictly with index. Each time a new sensor sample arrives, the block searches the sorted table for the segment that brackets the code. It interpolates along a straight line inside that segment and then adds one signed correction word that is shared by the whole table. The sum saturates at the ends of the DAC range.

The search is a binary search, one index bit per cycle. A single bit-serial divider forms the interpolation quotient. The result appears with a one-cycle done strobe, a fixed number of cycles after the sample is taken. Samples and table writes that arrive while a conversion is in flight are dropped.

Top module: `caltab_interp`

## Requirements
- R1: After reset, `dac_word` is 0 and `done` is 0.
- R2: A table write with `wr_en` high while idle stores the pair (`wr_code`, `wr_dac`) at index `wr_addr`, and a later conversion reads that pair back.
- R3: For a code x with c[i] < x < c[i+1], the result is d[i] + floor(|d[i+1]-d[i]| * (x-c[i]) / (c[i+1]-c[i])) when d[i+1] >= d[i], and d[i] minus that same quotient otherwise. The step is truncated toward d[i].
- R4: A code equal to a stored code c[i] returns exactly d[i].
- R5: A code below c[0] returns d[0], with no extrapolation.
- R6: A code at or above the last stored code returns the last entry's DAC value.
- R7: `corr_word` is a two's-complement signed value. It is captured together with the sample and added to the interpolated value.
- R8: The sum of the interpolated value and the correction saturates to the range 0 to 65535.
- R9: `done` is a one-cycle pulse. It arrives exactly clog2(DEPTH) + CODE_W + DAC_W + 2 clock edges after the edge that accepts the sample. `dac_word` changes only in the cycle where `done` is high.
- R10: `sample_valid` asserted while a conversion is in flight is ignored. The result and the timing of the running conversion are unaffected.
- R11: A table write asserted while a conversion is in flight is ignored. The table keeps its previous contents.
- R12: The search picks the largest index whose stored code does not exceed the sample code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Starts a conversion when idle |
| sample_code | input | CODE_W | Sensor code to convert |
| corr_word | input | DAC_W | Signed global correction, captured with the sample |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | clog2(DEPTH) | Table index to write |
| wr_code | input | CODE_W | Sensor code of the pair |
| wr_dac | input | DAC_W | DAC value of the pair |
| dac_word | output | DAC_W | Corrected, saturated tuning word |
| done | output | 1 | One-cycle pulse when `dac_word` is updated |

## Verification
The bench keeps both widths at 16 bits, so the arithmetic, the 32-bit product and the saturation limits are the real ones. It shrinks the table to DEPTH = 6. That is not a power of two, so the search meets probe indices past the last entry that it must skip, and the three search steps keep each conversion at 37 cycles. With only six entries, every segment, both clamp regions and every exact breakpoint are reachable within a few dozen conversions over several random non-uniform tables.

// File: rtl/caltab_pkg.sv
package caltab_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_PREP = 2'd2,
    ST_DIV  = 2'd3
  } conv_state_t;
endpackage

// File: rtl/cal_store.sv
module cal_store #(
  parameter int DEPTH = 136,
  parameter int CW    = 16,
  parameter int DW    = 16,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wcode,
  input  logic [DW-1:0] wdac,
  input  logic [AW-1:0] probe_addr,
  output logic [CW-1:0] probe_code,
  input  logic [AW-1:0] seg_addr,
  output logic [CW-1:0] lo_code,
  output logic [DW-1:0] lo_dac,
  output logic [CW-1:0] hi_code,
  output logic [DW-1:0] hi_dac
);
  logic [CW-1:0] code_q [DEPTH];
  logic [DW-1:0] dac_q  [DEPTH];
  logic [AW:0]   nxt;
  logic [AW-1:0] hi_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        code_q[i] <= '0;
        dac_q[i]  <= '0;
      end
    end else if (we) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (waddr == AW'(i)) begin
          code_q[i] <= wcode;
          dac_q[i]  <= wdac;
        end
      end
    end
  end

  assign nxt    = {1'b0, seg_addr} + 1'b1;
  assign hi_sel = (nxt < (AW+1)'(DEPTH)) ? nxt[AW-1:0] : seg_addr;

  assign probe_code = (probe_addr < AW'(DEPTH)) ? code_q[probe_addr] : '0;
  assign lo_code    = code_q[seg_addr];
  assign lo_dac     = dac_q[seg_addr];
  assign hi_code    = code_q[hi_sel];
  assign hi_dac     = dac_q[hi_sel];
endmodule

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int NW = 32,
  parameter int DW = 16,
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [QW-1:0] quo,
  output logic          fin
);
  localparam int CNTW = $clog2(NW + 1);

  logic [NW-1:0]   num_q;
  logic [DW-1:0]   den_q;
  logic [DW-1:0]   rem_q;
  logic [QW-1:0]   quo_q;
  logic [CNTW-1:0] cnt_q;
  logic            run_q;
  logic            fin_q;
  logic [DW:0]     trial;
  logic            ge;
  logic [DW-1:0]   diff;

  assign trial = {rem_q, num_q[NW-1]};
  assign ge    = trial >= {1'b0, den_q};
  assign diff  = trial[DW-1:0] - den_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
      den_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start) begin
        num_q <= num;
        den_q <= den;
        rem_q <= '0;
        quo_q <= '0;
        cnt_q <= CNTW'(NW);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff : trial[DW-1:0];
        num_q <= {num_q[NW-2:0], 1'b0};
        quo_q <= {quo_q[QW-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNTW'(1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign quo = quo_q;
  assign fin = fin_q;
endmodule

// File: rtl/caltab_interp.sv
module caltab_interp
  import caltab_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int DAC_W  = 16,
  parameter int DEPTH  = 136
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_valid,
  input  logic [CODE_W-1:0]        sample_code,
  input  logic [DAC_W-1:0]         corr_word,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [CODE_W-1:0]        wr_code,
  input  logic [DAC_W-1:0]         wr_dac,
  output logic [DAC_W-1:0]         dac_word,
  output logic                     done
);
  localparam int AW         = $clog2(DEPTH);
  localparam int SEEK_STEPS = AW;
  localparam int PW         = CODE_W + DAC_W;
  localparam int SW         = $clog2(SEEK_STEPS + 1);
  localparam int LATENCY    = SEEK_STEPS + PW + 2;

  // arithmetic kept in functions
  function automatic logic [DAC_W-1:0] seg_apply(input logic [DAC_W-1:0] base,
                                                 input logic [DAC_W-1:0] step,
                                                 input logic             down);
    return down ? base - step : base + step;
  endfunction

  function automatic logic [DAC_W-1:0] sat_add(input logic [DAC_W-1:0] v,
                                               input logic [DAC_W-1:0] c);
    logic signed [DAC_W+1:0] s;
    s = $signed({2'b00, v}) + $signed({{2{c[DAC_W-1]}}, c});
    if (s < 0) return '0;
    if (s > $signed({2'b00, {DAC_W{1'b1}}})) return '1;
    return s[DAC_W-1:0];
  endfunction

  conv_state_t       state_q;
  logic [SW-1:0]     step_q;
  logic [AW-1:0]     idx_q;
  logic [CODE_W-1:0] x_q;
  logic [DAC_W-1:0]  corr_q;
  logic [DAC_W-1:0]  base_q;
  logic              neg_q;
  logic [DAC_W-1:0]  dac_q;
  logic              done_q;

  // named events for the checker
  logic              busy;
  logic              accept_ev;
  logic              prep_ev;
  logic              store_we;
  logic              at_top;

  logic [AW:0]       cand;
  logic              cand_in;
  logic              take;
  logic [CODE_W-1:0] probe_code;
  logic [CODE_W-1:0] lo_code;
  logic [CODE_W-1:0] hi_code;
  logic [DAC_W-1:0]  lo_dac;
  logic [DAC_W-1:0]  hi_dac;

  logic [CODE_W-1:0] dx;
  logic [CODE_W-1:0] span;
  logic [CODE_W-1:0] div_den;
  logic              dd_neg;
  logic [DAC_W-1:0]  dd_mag;
  logic [PW-1:0]     div_num;
  logic [DAC_W-1:0]  div_quo;
  logic              div_fin;

  assign busy      = (state_q != ST_IDLE);
  assign accept_ev = sample_valid && !busy;
  assign prep_ev   = (state_q == ST_PREP);
  assign store_we  = wr_en && !busy;

  // binary search: one index bit per cycle, most significant first
  assign cand    = {1'b0, idx_q} | ((AW+1)'(1) << step_q);
  assign cand_in = cand < (AW+1)'(DEPTH);
  assign take    = cand_in && (probe_code <= x_q);

  cal_store #(
    .DEPTH(DEPTH),
    .CW   (CODE_W),
    .DW   (DAC_W),
    .AW   (AW)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (store_we),
    .waddr     (wr_addr),
    .wcode     (wr_code),
    .wdac      (wr_dac),
    .probe_addr(cand[AW-1:0]),
    .probe_code(probe_code),
    .seg_addr  (idx_q),
    .lo_code   (lo_code),
    .lo_dac    (lo_dac),
    .hi_code   (hi_code),
    .hi_dac    (hi_dac)
  );

  // segment operands
  assign at_top  = (idx_q == AW'(DEPTH - 1));
  assign dx      = (!at_top && (x_q > lo_code)) ? x_q - lo_code : '0;
  assign span    = hi_code - lo_code;
  assign div_den = ((dx == '0) || (span == '0)) ? CODE_W'(1) : span;
  assign dd_neg  = hi_dac < lo_dac;
  assign dd_mag  = dd_neg ? lo_dac - hi_dac : hi_dac - lo_dac;
  assign div_num = {{CODE_W{1'b0}}, dd_mag} * {{DAC_W{1'b0}}, dx};

  cal_divider #(
    .NW(PW),
    .DW(CODE_W),
    .QW(DAC_W)
  ) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(prep_ev),
    .num  (div_num),
    .den  (div_den),
    .quo  (div_quo),
    .fin  (div_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      idx_q   <= '0;
      x_q     <= '0;
      corr_q  <= '0;
      base_q  <= '0;
      neg_q   <= 1'b0;
      dac_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (sample_valid) begin
            x_q     <= sample_code;
            corr_q  <= corr_word;
            idx_q   <= '0;
            step_q  <= SW'(SEEK_STEPS - 1);
            state_q <= ST_SEEK;
          end
        end
        ST_SEEK: begin
          if (take) idx_q <= cand[AW-1:0];
          if (step_q == '0) state_q <= ST_PREP;
          else              step_q  <= step_q - 1'b1;
        end
        ST_PREP: begin
          base_q  <= lo_dac;
          neg_q   <= dd_neg;
          state_q <= ST_DIV;
        end
        ST_DIV: begin
          if (div_fin) begin
            dac_q   <= sat_add(seg_apply(base_q, div_quo, neg_q), corr_q);
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dac_word = dac_q;
  assign done     = done_q;
endmodule

// File: rtl/caltab_interp_chk.sv
module caltab_interp_chk #(
  parameter int AW      = 8,
  parameter int CW      = 16,
  parameter int DW      = 16,
  parameter int LATENCY = 42
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept_ev,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] dac_word,
  input logic          prep_ev,
  input logic [AW-1:0] seg_idx,
  input logic [CW-1:0] x_q,
  input logic [CW-1:0] lo_code,
  input logic [CW-1:0] hi_code,
  input logic          at_top
);
  logic [15:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc_q <= '0;
    else if (accept_ev) cyc_q <= '0;
    else if (busy)      cyc_q <= cyc_q + 1'b1;
  end

  // R9
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_q == 16'(LATENCY)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(dac_word));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> busy);

  // R12
  bracket_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prep_ev && (seg_idx != '0)) |-> (lo_code <= x_q));

  // R12
  bracket_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prep_ev && !at_top) |-> (hi_code > x_q));
endmodule

bind caltab_interp caltab_interp_chk #(
  .AW     (AW),
  .CW     (CODE_W),
  .DW     (DAC_W),
  .LATENCY(LATENCY)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept_ev(accept_ev),
  .busy     (busy),
  .done     (done),
  .dac_word (dac_word),
  .prep_ev  (prep_ev),
  .seg_idx  (idx_q),
  .x_q      (x_q),
  .lo_code  (lo_code),
  .hi_code  (hi_code),
  .at_top   (at_top)
);

// File: tb/sim_caltab_interp.sv
module sim_caltab_interp;
  localparam int N   = 6;
  localparam int AW  = 3;
  localparam int LAT = 3 + 16 + 16 + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_valid = 1'b0;
  logic [15:0]   sample_code = '0;
  logic [15:0]   corr_word = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_code = '0;
  logic [15:0]   wr_dac = '0;
  logic [15:0]   dac_word;
  logic          done;

  int checks = 0;
  int fails  = 0;
  int tc [N];
  int td [N];

  always #2 clk = ~clk;

  caltab_interp #(.CODE_W(16), .DAC_W(16), .DEPTH(N)) u0 (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_code(sample_code),
    .corr_word(corr_word), .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
    .wr_dac(wr_dac), .dac_word(dac_word), .done(done));

  function automatic int model(input int x, input int c);
    int i = 0;
    int v;
    longint mag, q;
    for (int j = 0; j < N; j++) if (tc[j] <= x) i = j;
    if (x < tc[0]) v = td[0];
    else if (i == N - 1 || x == tc[i]) v = td[i];
    else begin
      mag = (td[i+1] >= td[i]) ? longint'(td[i+1] - td[i]) : longint'(td[i] - td[i+1]);
      q = (mag * longint'(x - tc[i])) / longint'(tc[i+1] - tc[i]);
      v = (td[i+1] >= td[i]) ? td[i] + int'(q) : td[i] - int'(q);
    end
    v = v + c;
    if (v < 0) v = 0;
    if (v > 65535) v = 65535;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic write_entry(input int i, input int code, input int dac);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(i); wr_code = code[15:0]; wr_dac = dac[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_table();
    for (int i = 0; i < N; i++) write_entry(i, tc[i], td[i]);
  endtask

  task automatic random_table(input int lo, input int maxgap);
    int c = lo;
    for (int i = 0; i < N; i++) begin
      tc[i] = c;
      td[i] = int'($urandom_range(0, 65535));
      c = c + 1 + int'($urandom_range(0, maxgap));
    end
    load_table();
  endtask

  // inject: 0 none, 1 extra sample mid-flight, 2 write mid-flight
  task automatic run_one(input int x, input int c, input int inject, input string tag);
    int k;
    int exp_v;
    exp_v = model(x, c);
    @(negedge clk);
    sample_valid = 1'b1; sample_code = x[15:0]; corr_word = c[15:0];
    @(posedge clk);
    k = 0;
    @(negedge clk);
    sample_valid = 1'b0;
    while (!done && k < 200) begin
      if (k == 10 && inject == 1) begin
        sample_valid = 1'b1; sample_code = ~x[15:0]; corr_word = 16'h7FFF;
      end else if (k == 10 && inject == 2) begin
        wr_en = 1'b1; wr_addr = AW'(1); wr_code = 16'(tc[1]); wr_dac = 16'd5;
      end else begin
        sample_valid = 1'b0; wr_en = 1'b0;
      end
      @(posedge clk);
      k++;
      @(negedge clk);
    end
    sample_valid = 1'b0; wr_en = 1'b0;
    check(tag, int'(dac_word), exp_v);
    check("R9 latency", k, LAT);
    @(negedge clk);
    check("R9 pulse", int'(done), 0);
    check("R9 hold", int'(dac_word), exp_v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 word", int'(dac_word), 0);
    check("R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    tc = '{1000, 3000, 3500, 20000, 40000, 60000};
    td = '{100, 30000, 29000, 45000, 45000, 65000};
    load_table();
    for (int i = 0; i < N; i++) run_one(tc[i], 0, 0, "R2 R4 exact");
    run_one(0, 0, 0, "R5 below");
    run_one(999, 0, 0, "R5 below");
    run_one(60000, 0, 0, "R6 top");
    run_one(65535, 0, 0, "R6 above");
    run_one(2000, 0, 0, "R3 rising");
    run_one(3250, 0, 0, "R3 falling");
    run_one(3499, 0, 0, "R3 R12 edge");
    run_one(3001, 0, 0, "R3 R12 edge");
    run_one(30000, 0, 0, "R3 flat");
    run_one(3000, 123, 0, "R7 positive");
    run_one(3000, -500, 0, "R7 negative");
    run_one(65535, 1000, 0, "R8 high");
    run_one(0, -200, 0, "R8 low");
    run_one(500, -32768, 0, "R8 min corr");
    run_one(59000, 32767, 0, "R8 max corr");
    run_one(2000, 0, 1, "R10 sample mid-flight");
    run_one(2000, 0, 2, "R11 write mid-flight");
    run_one(tc[1], 0, 0, "R11 entry kept");

    for (int t = 0; t < 3; t++) begin
      random_table(int'($urandom_range(0, 4000)), 10000);
      for (int i = 0; i < N; i++) run_one(tc[i], 0, 0, "R2 R4 exact");
      for (int s = 0; s < 20; s++) begin
        int x;
        int sel = int'($urandom_range(0, 3));
        int e = int'($urandom_range(0, N - 1));
        if (sel == 0)      x = tc[e] + 1;
        else if (sel == 1) x = (tc[e] > 0) ? tc[e] - 1 : 0;
        else               x = int'($urandom_range(0, 65535));
        if (x > 65535) x = 65535;
        run_one(x, int'($urandom_range(0, 4000)) - 2000, 0, "R3 R7 R12 random");
      end
    end

    report();
    $finish;
  end
endmodule